// File: doc/BRIEF.md
# Second-Operand Shifter and Rotated-Immediate Generator

This block forms the 32-bit second operand that a data-processing instruction feeds into the ALU of a small RISC datapath. It produces that operand together with the shifter carry-out, which a later stage may load into the carry flag. It is purely combinational. A single select input chooses one of two ways to form the operand.

In immediate mode, an 8-bit constant is zero-extended to 32 bits and rotated right by twice a 4-bit rotate field, so that any byte can be placed at any even bit position of the word. In register mode, a 32-bit register value is shifted or rotated. The shift kind is chosen by a 2-bit code. The amount comes either from a 5-bit immediate field or from the low byte of a second register. Because a register can supply amounts up to 255, every amount has a defined result and carry.

Instruction decode, the ALU, the flag registers and conditional execution are handled elsewhere.

Top module: `opnd_unit`

## Requirements
- R1: When `sel_imm` is 1, `operand` equals `imm_byte` zero-extended to 32 bits and rotated right by 2*`imm_rot` positions, giving a rotation count from 0 to 30.
- R2: When `sel_imm` is 1, `carry_out` equals `operand[31]` if `imm_rot` is nonzero, and equals `carry_in` if `imm_rot` is zero.
- R3: When `sel_imm` is 0, the shift amount is `amt_src[7:0]` if `amt_from_reg` is 1, and bits 31..8 of `amt_src` have no effect. Otherwise the amount is `amt_imm` zero-extended.
- R4: When `sel_imm` is 0 and the amount is 0, `operand` equals `src_val` and `carry_out` equals `carry_in`, for every shift kind.
- R5: `shift_kind` is encoded as 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right. A logical left shift by 1..31 fills zeros on the right, and `carry_out` is the last bit shifted out, which is `src_val[32-n]`.
- R6: A logical right shift or an arithmetic right shift by 1..31 sets `carry_out` to `src_val[n-1]`. The logical kind fills zeros at the top, and the arithmetic kind fills copies of `src_val[31]`.
- R7: A logical shift by exactly 32 gives `operand` 0. `carry_out` is `src_val[0]` for a left shift and `src_val[31]` for a right shift.
- R8: A logical shift, left or right, by more than 32 gives `operand` 0 and `carry_out` 0.
- R9: An arithmetic right shift by 32 or more sets all 32 bits of `operand`, and `carry_out`, to `src_val[31]`.
- R10: A rotate right by a nonzero amount n rotates by n mod 32, and `carry_out` equals `operand[31]`. A nonzero multiple of 32 leaves `src_val` unchanged.
- R11: When `sel_imm` is 1, the register-mode inputs have no effect on the outputs. When `sel_imm` is 0, `imm_byte` and `imm_rot` have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sel_imm | input | 1 | 1 selects the rotated immediate, 0 selects the shifted register |
| imm_byte | input | 8 | Immediate constant byte |
| imm_rot | input | 4 | Rotate field; the rotation is twice this value |
| src_val | input | 32 | Register value to shift or rotate |
| shift_kind | input | 2 | Shift code: 00 LSL, 01 LSR, 10 ASR, 11 ROR |
| amt_from_reg | input | 1 | 1 takes the amount from `amt_src[7:0]`, 0 from `amt_imm` |
| amt_imm | input | 5 | Immediate shift amount |
| amt_src | input | 32 | Register supplying the shift amount in its low byte |
| carry_in | input | 1 | Current carry flag |
| operand | output | 32 | Second operand |
| carry_out | output | 1 | Shifter carry-out |

## Verification
The assertions are immediate checks on settled combinational values. They assume that every input is a known 0 or 1 whenever it is sampled, and that the inputs stay constant between one evaluation and the next. The bench changes every input together just after a rising clock edge and reads the outputs at the falling edge, so each check sees stable inputs with no X or Z bits. The random phase draws shift amounts from biased buckets that include 0, 31, 32, 33, multiples of 32 and values up to 255. This lets the range-dependent assertions fire on real stimulus.

// File: rtl/opnd_pkg.sv
package opnd_pkg;
  typedef enum logic [1:0] {
    SK_LSL = 2'b00,
    SK_LSR = 2'b01,
    SK_ASR = 2'b10,
    SK_ROR = 2'b11
  } shift_kind_e;
endpackage

// File: rtl/opnd_amt_sel.sv
module opnd_amt_sel #(
  parameter int IMM_AMT_W = 5,
  parameter int REG_AMT_W = 8
) (
  input  logic                 from_reg,
  input  logic [IMM_AMT_W-1:0] amt_imm,
  input  logic [REG_AMT_W-1:0] amt_low,
  output logic [REG_AMT_W-1:0] amt
);
  localparam int PAD_W = REG_AMT_W - IMM_AMT_W;

  logic [REG_AMT_W-1:0] imm_ext;

  generate
    if (PAD_W > 0) begin : g_pad
      assign imm_ext = {{PAD_W{1'b0}}, amt_imm};
    end else begin : g_nopad
      assign imm_ext = amt_imm[REG_AMT_W-1:0];
    end
  endgenerate

  always_comb begin
    amt = from_reg ? amt_low : imm_ext;
  end
endmodule

// File: rtl/opnd_imm_rot.sv
module opnd_imm_rot #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4
) (
  input  logic [IMM_W-1:0]  imm_byte,
  input  logic [ROT_W-1:0]  imm_rot,
  input  logic              carry_in,
  output logic [DATA_W-1:0] result,
  output logic              carry_out
);
  localparam int CNT_W = ROT_W + 1;

  logic [DATA_W-1:0]   base;
  logic [2*DATA_W-1:0] dbl;
  logic [CNT_W-1:0]    rot_cnt;

  always_comb begin
    base    = {{(DATA_W-IMM_W){1'b0}}, imm_byte};
    rot_cnt = {imm_rot, 1'b0};
    dbl     = {base, base} >> rot_cnt;
    result  = dbl[DATA_W-1:0];
    carry_out = (imm_rot == '0) ? carry_in : result[DATA_W-1];
  end
endmodule

// File: rtl/opnd_reg_shift.sv
module opnd_reg_shift
  import opnd_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int REG_AMT_W = 8
) (
  input  logic [DATA_W-1:0]    val,
  input  shift_kind_e          kind,
  input  logic [REG_AMT_W-1:0] amt,
  input  logic                 carry_in,
  output logic [DATA_W-1:0]    result,
  output logic                 carry_out
);
  localparam int SH_W = $clog2(DATA_W);
  localparam logic [REG_AMT_W-1:0] FULL = REG_AMT_W'(DATA_W);
  localparam logic [SH_W:0]        FULL_C = (SH_W+1)'(DATA_W);

  logic [SH_W:0]        clamp;
  logic                 over;
  logic [DATA_W:0]      lsl_ext;
  logic [DATA_W:0]      lsr_ext;
  logic signed [DATA_W:0] asr_src;
  logic signed [DATA_W:0] asr_ext;
  logic [2*DATA_W-1:0]  ror_dbl;
  logic [DATA_W-1:0]    ror_res;

  always_comb begin
    clamp   = (amt >= FULL) ? FULL_C : amt[SH_W:0];
    over    = (amt > FULL);
    lsl_ext = {1'b0, val} << clamp;
    lsr_ext = {val, 1'b0} >> clamp;
    asr_src = {val, 1'b0};
    asr_ext = asr_src >>> clamp;
    ror_dbl = {val, val} >> amt[SH_W-1:0];
    ror_res = ror_dbl[DATA_W-1:0];
  end

  always_comb begin
    result    = val;
    carry_out = carry_in;
    if (amt != '0) begin
      unique case (kind)
        SK_LSL: begin
          result    = over ? '0 : lsl_ext[DATA_W-1:0];
          carry_out = over ? 1'b0 : lsl_ext[DATA_W];
        end
        SK_LSR: begin
          result    = over ? '0 : lsr_ext[DATA_W:1];
          carry_out = over ? 1'b0 : lsr_ext[0];
        end
        SK_ASR: begin
          result    = asr_ext[DATA_W:1];
          carry_out = asr_ext[0];
        end
        SK_ROR: begin
          result    = ror_res;
          carry_out = ror_res[DATA_W-1];
        end
        default: begin
          result    = val;
          carry_out = carry_in;
        end
      endcase
    end
  end
endmodule

// File: rtl/opnd_unit.sv
module opnd_unit
  import opnd_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int IMM_W     = 8,
  parameter int ROT_W     = 4,
  parameter int IMM_AMT_W = 5,
  parameter int REG_AMT_W = 8
) (
  input  logic                 sel_imm,
  input  logic [IMM_W-1:0]     imm_byte,
  input  logic [ROT_W-1:0]     imm_rot,
  input  logic [DATA_W-1:0]    src_val,
  input  logic [1:0]           shift_kind,
  input  logic                 amt_from_reg,
  input  logic [IMM_AMT_W-1:0] amt_imm,
  input  logic [DATA_W-1:0]    amt_src,
  input  logic                 carry_in,
  output logic [DATA_W-1:0]    operand,
  output logic                 carry_out
);
  logic [REG_AMT_W-1:0] amt_eff;
  logic [DATA_W-1:0]    imm_res;
  logic                 imm_c;
  logic [DATA_W-1:0]    sh_res;
  logic                 sh_c;
  logic                 unused_amt_hi;

  assign unused_amt_hi = ^amt_src[DATA_W-1:REG_AMT_W];

  opnd_amt_sel #(
    .IMM_AMT_W (IMM_AMT_W),
    .REG_AMT_W (REG_AMT_W)
  ) u_amt (
    .from_reg (amt_from_reg),
    .amt_imm  (amt_imm),
    .amt_low  (amt_src[REG_AMT_W-1:0]),
    .amt      (amt_eff)
  );

  opnd_imm_rot #(
    .DATA_W (DATA_W),
    .IMM_W  (IMM_W),
    .ROT_W  (ROT_W)
  ) u_imm (
    .imm_byte  (imm_byte),
    .imm_rot   (imm_rot),
    .carry_in  (carry_in),
    .result    (imm_res),
    .carry_out (imm_c)
  );

  opnd_reg_shift #(
    .DATA_W    (DATA_W),
    .REG_AMT_W (REG_AMT_W)
  ) u_sh (
    .val       (src_val),
    .kind      (shift_kind_e'(shift_kind)),
    .amt       (amt_eff),
    .carry_in  (carry_in),
    .result    (sh_res),
    .carry_out (sh_c)
  );

  always_comb begin
    operand   = sel_imm ? imm_res : sh_res;
    carry_out = sel_imm ? imm_c   : sh_c;
  end
endmodule

// File: rtl/opnd_unit_chk.sv
module opnd_unit_chk #(
  parameter int DATA_W    = 32,
  parameter int IMM_W     = 8,
  parameter int ROT_W     = 4,
  parameter int IMM_AMT_W = 5,
  parameter int REG_AMT_W = 8
) (
  input logic                 sel_imm,
  input logic [IMM_W-1:0]     imm_byte,
  input logic [ROT_W-1:0]     imm_rot,
  input logic [DATA_W-1:0]    src_val,
  input logic [1:0]           shift_kind,
  input logic                 amt_from_reg,
  input logic [IMM_AMT_W-1:0] amt_imm,
  input logic [DATA_W-1:0]    amt_src,
  input logic                 carry_in,
  input logic [DATA_W-1:0]    operand,
  input logic                 carry_out
);
  localparam int FULL = DATA_W;

  int unsigned reg_amt;
  int unsigned imm_amt;

  always_comb begin
    reg_amt = int'(amt_src[REG_AMT_W-1:0]);
    imm_amt = int'(amt_imm);

    if (sel_imm && imm_rot == '0)
      AST_IMM_NO_ROT: assert (operand == DATA_W'(imm_byte) && carry_out == carry_in); // R1
    if (sel_imm && imm_rot != '0)
      AST_IMM_CARRY: assert (carry_out == operand[DATA_W-1]); // R2
    if (!sel_imm && ((amt_from_reg && reg_amt == 0) || (!amt_from_reg && imm_amt == 0)))
      AST_ZERO_AMT_PASS: assert (operand == src_val && carry_out == carry_in); // R4
    if (!sel_imm && amt_from_reg && reg_amt > FULL && !shift_kind[1])
      AST_LOGIC_OVER_ZERO: assert (operand == '0 && !carry_out); // R8
    if (!sel_imm && amt_from_reg && reg_amt >= FULL && shift_kind == 2'b10)
      AST_ASR_SIGN_FILL: assert (operand == {DATA_W{src_val[DATA_W-1]}} && carry_out == src_val[DATA_W-1]); // R9
    if (!sel_imm && shift_kind == 2'b11 && amt_from_reg && reg_amt != 0)
      AST_ROR_CARRY_TOP: assert (carry_out == operand[DATA_W-1]); // R10
  end
endmodule

bind opnd_unit opnd_unit_chk #(
  .DATA_W    (DATA_W),
  .IMM_W     (IMM_W),
  .ROT_W     (ROT_W),
  .IMM_AMT_W (IMM_AMT_W),
  .REG_AMT_W (REG_AMT_W)
) u_chk (
  .sel_imm      (sel_imm),
  .imm_byte     (imm_byte),
  .imm_rot      (imm_rot),
  .src_val      (src_val),
  .shift_kind   (shift_kind),
  .amt_from_reg (amt_from_reg),
  .amt_imm      (amt_imm),
  .amt_src      (amt_src),
  .carry_in     (carry_in),
  .operand      (operand),
  .carry_out    (carry_out)
);

// File: tb/tb_opnd_unit.sv
module tb_opnd_unit;
  logic        clk;
  logic        rst_n;
  logic        sel_imm;
  logic [7:0]  imm_byte;
  logic [3:0]  imm_rot;
  logic [31:0] src_val;
  logic [1:0]  shift_kind;
  logic        amt_from_reg;
  logic [4:0]  amt_imm;
  logic [31:0] amt_src;
  logic        carry_in;
  logic [31:0] operand;
  logic        carry_out;

  int checks;
  int errors;

  opnd_unit dut (
    .sel_imm      (sel_imm),
    .imm_byte     (imm_byte),
    .imm_rot      (imm_rot),
    .src_val      (src_val),
    .shift_kind   (shift_kind),
    .amt_from_reg (amt_from_reg),
    .amt_imm      (amt_imm),
    .amt_src      (amt_src),
    .carry_in     (carry_in),
    .operand      (operand),
    .carry_out    (carry_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Behavioural reference: one bit position per step.
  function automatic void ref_model(output logic [31:0] r, output logic c);
    logic [31:0] v;
    logic        cc;
    int          n;
    if (sel_imm) begin
      v  = {24'd0, imm_byte};
      cc = carry_in;
      for (int i = 0; i < 2 * int'(imm_rot); i++) begin
        v = {v[0], v[31:1]};
      end
      if (imm_rot != 4'd0) cc = v[31];
    end else begin
      v  = src_val;
      cc = carry_in;
      n  = amt_from_reg ? int'(amt_src[7:0]) : int'(amt_imm);
      for (int i = 0; i < n; i++) begin
        case (shift_kind)
          2'b00: begin cc = v[31]; v = {v[30:0], 1'b0}; end
          2'b01: begin cc = v[0];  v = {1'b0, v[31:1]}; end
          2'b10: begin cc = v[0];  v = {v[31], v[31:1]}; end
          default: begin cc = v[0]; v = {v[0], v[31:1]}; end
        endcase
      end
    end
    r = v;
    c = cc;
  endfunction

  function automatic string tag_of();
    int n;
    if (sel_imm) return (imm_rot == 0) ? "R1/R2" : "R1";
    n = amt_from_reg ? int'(amt_src[7:0]) : int'(amt_imm);
    if (n == 0) return "R4";
    case (shift_kind)
      2'b00:   return (n < 32) ? "R5" : (n == 32) ? "R7" : "R8";
      2'b01:   return (n < 32) ? "R6" : (n == 32) ? "R7" : "R8";
      2'b10:   return (n < 32) ? "R6" : "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check_now(input string req);
    logic [31:0] er;
    logic        ec;
    ref_model(er, ec);
    checks++;
    if (operand !== er || carry_out !== ec) begin
      errors++;
      $display("FAIL %s: operand=%08h carry=%0b expected operand=%08h carry=%0b",
               req, operand, carry_out, er, ec);
    end
  endtask

  task automatic drive(input logic si, input logic [7:0] ib, input logic [3:0] ir,
                       input logic [31:0] sv, input logic [1:0] sk, input logic fr,
                       input logic [4:0] ai, input logic [31:0] as, input logic ci);
    @(posedge clk);
    #1;
    sel_imm = si; imm_byte = ib; imm_rot = ir; src_val = sv; shift_kind = sk;
    amt_from_reg = fr; amt_imm = ai; amt_src = as; carry_in = ci;
    @(negedge clk);
  endtask

  task automatic vec(input logic si, input logic [7:0] ib, input logic [3:0] ir,
                     input logic [31:0] sv, input logic [1:0] sk, input logic fr,
                     input logic [4:0] ai, input logic [31:0] as, input logic ci);
    drive(si, ib, ir, sv, sk, fr, ai, as, ci);
    check_now(tag_of());
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] first_op;
    logic        first_c;
    checks = 0;
    errors = 0;
    rst_n = 1'b0;
    sel_imm = 0; imm_byte = 0; imm_rot = 0; src_val = 0; shift_kind = 0;
    amt_from_reg = 0; amt_imm = 0; amt_src = 0; carry_in = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_now("R4 initial state");

    // R1 / R2: byte at every even position
    vec(1, 8'hFF, 4'd0, 32'h0, 0, 0, 0, 0, 1);
    vec(1, 8'hFF, 4'd4, 32'h0, 0, 0, 0, 0, 0);
    vec(1, 8'hFF, 4'd8, 32'h0, 0, 0, 0, 0, 0);
    vec(1, 8'hFF, 4'd12, 32'h0, 0, 0, 0, 0, 0);
    vec(1, 8'h81, 4'd1, 32'h0, 0, 0, 0, 0, 1);
    vec(1, 8'h01, 4'd15, 32'h0, 0, 0, 0, 0, 1);
    // R3: upper bits of amount register ignored
    vec(0, 0, 0, 32'h8000_00F1, 2'b01, 1, 5'd0, 32'hFFFF_FF04, 0);
    vec(0, 0, 0, 32'h8000_00F1, 2'b01, 0, 5'd4, 32'hFFFF_FF00, 0);
    // R4: zero amount on each kind
    for (int k = 0; k < 4; k++) vec(0, 0, 0, 32'hDEAD_BEEF, 2'(k), 1, 5'd7, 32'h0000_1200, 1);
    for (int k = 0; k < 4; k++) vec(0, 0, 0, 32'h1234_5678, 2'(k), 0, 5'd0, 32'h0, 0);
    // R5 / R6: 1..31
    vec(0, 0, 0, 32'hC000_0001, 2'b00, 0, 5'd1, 0, 0);
    vec(0, 0, 0, 32'h0000_0001, 2'b00, 0, 5'd31, 0, 0);
    vec(0, 0, 0, 32'h8000_0003, 2'b01, 0, 5'd2, 0, 0);
    vec(0, 0, 0, 32'h8000_0000, 2'b10, 0, 5'd31, 0, 0);
    vec(0, 0, 0, 32'h4000_0010, 2'b10, 1, 5'd0, 32'd5, 1);
    // R7 / R8 / R9
    vec(0, 0, 0, 32'h0000_0001, 2'b00, 1, 0, 32'd32, 0);
    vec(0, 0, 0, 32'h8000_0000, 2'b01, 1, 0, 32'd32, 0);
    vec(0, 0, 0, 32'hFFFF_FFFF, 2'b00, 1, 0, 32'd33, 1);
    vec(0, 0, 0, 32'hFFFF_FFFF, 2'b01, 1, 0, 32'd255, 1);
    vec(0, 0, 0, 32'h8000_0000, 2'b10, 1, 0, 32'd32, 0);
    vec(0, 0, 0, 32'h7FFF_FFFF, 2'b10, 1, 0, 32'd200, 1);
    // R10
    vec(0, 0, 0, 32'h8000_0001, 2'b11, 1, 0, 32'd1, 0);
    vec(0, 0, 0, 32'h8765_4321, 2'b11, 1, 0, 32'd64, 0);
    vec(0, 0, 0, 32'h0765_4321, 2'b11, 1, 0, 32'd32, 1);
    vec(0, 0, 0, 32'h0000_0100, 2'b11, 1, 0, 32'd41, 0);

    // R11: immediate mode insensitive to register inputs
    drive(1, 8'h3C, 4'd5, 32'h0, 2'b00, 0, 0, 0, 0);
    first_op = operand; first_c = carry_out;
    drive(1, 8'h3C, 4'd5, 32'hFFFF_FFFF, 2'b11, 1, 5'd9, 32'd77, 0);
    checks++;
    if (operand !== first_op || carry_out !== first_c) begin
      errors++;
      $display("FAIL R11: operand=%08h carry=%0b expected operand=%08h carry=%0b",
               operand, carry_out, first_op, first_c);
    end
    // R11: register mode insensitive to immediate inputs
    drive(0, 8'h00, 4'd0, 32'hA5A5_0F0F, 2'b10, 0, 5'd3, 0, 1);
    first_op = operand; first_c = carry_out;
    drive(0, 8'hFF, 4'd9, 32'hA5A5_0F0F, 2'b10, 0, 5'd3, 0, 1);
    checks++;
    if (operand !== first_op || carry_out !== first_c) begin
      errors++;
      $display("FAIL R11: operand=%08h carry=%0b expected operand=%08h carry=%0b",
               operand, carry_out, first_op, first_c);
    end

    // Random sweep with biased amounts
    for (int i = 0; i < 600; i++) begin
      logic [31:0] as;
      case ($urandom_range(0, 5))
        0: as = 32'd0;
        1: as = 32'($urandom_range(30, 34));
        2: as = 32'(32 * $urandom_range(1, 7));
        default: as = 32'($urandom_range(0, 255));
      endcase
      as[31:8] = 24'($urandom);
      vec(1'($urandom), 8'($urandom), 4'($urandom), $urandom, 2'($urandom),
          1'($urandom), 5'($urandom), as, 1'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule